// File: doc/BRIEF.md
# Interrupt Controller Status Readback

This block is the CPU-facing read path of an eight-line programmable interrupt controller. It returns one of three registers on an 8-bit data bus during a processor read. The first is the pending-request register, the second is the in-service register, and the third is the line-mask register. The request and in-service vectors come in live from neighbouring logic. The mask register is held here and is loaded by a mask write.

The bus data for a read with the address bit low depends on a stored register choice. A status command word written earlier sets that choice, and it stays in force until another status command changes it. A read with the address bit high always returns the mask. A status command can also arm a poll. The next read with the address bit low then returns a poll byte instead of status. That byte carries a pending flag and the highest-priority unmasked pending level. After that read the stored choice falls back to the request register. An initialisation word also returns the choice to the request register.

Bus strobes are active low and sampled on the block clock. A write acts on the first clock where chip select and the write strobe are both low. A read ends on the first clock where that pair is no longer low.

Top module: `pic_status_read`

## Requirements
- R1: After synchronous reset the stored choice is the request register, the mask is 0x00 and no poll is armed.
- R2: A status command (address bit 0, data bit 4 = 0, bit 3 = 1) with bit 1 = 1 and bit 0 = 0 makes later address-0 reads return the request vector.
- R3: A status command with bit 1 = 1 and bit 0 = 1 makes later address-0 reads return the in-service vector.
- R4: The stored choice persists across any number of reads with no new command.
- R5: A status command with bit 1 = 0 and bit 2 = 0 leaves the stored choice unchanged.
- R6: A write with the address bit 1 loads the mask from the data bus. A read with the address bit 1 returns the mask whatever the stored choice is.
- R7: A status command with bit 2 = 1 arms a poll and leaves the choice alone. While the poll is armed, an address-0 read returns bit 7 = 1 if any request bit with a clear mask bit is set, and bits 2:0 = the lowest such line index. Every other bit is 0.
- R8: When an address-0 read ends with a poll armed, the poll is disarmed and the stored choice becomes the request register. An address-1 read leaves the poll armed.
- R9: An initialisation word (address bit 0, data bit 4 = 1) sets the choice to the request register, clears the mask and disarms any poll.
- R10: The output enable is 1 exactly while chip select and the read strobe are both low. The data output is 0x00 whenever the enable is 0.
- R11: An address-0 write with data bits 4:3 = 00 changes neither the stored choice, the mask nor the poll state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data from the CPU |
| irr_i | input | 8 | Live pending-request vector |
| isr_i | input | 8 | Live in-service vector |
| dout | output | 8 | Read data to the CPU |
| dout_oe | output | 1 | Bus drive enable (low means the bus floats) |

## Verification
The poll encoder is swept over all 256 request patterns under several masks. This exposes a design that reports the highest index instead of the lowest, ignores the mask, or sets the flag when nothing is pending. Each poll read is followed by a plain read, which catches a poll that stays armed or a choice that does not fall back to the request register. Back-to-back reads after one command catch a choice that resets on every read. The no-select command, an end-of-service-style write and a mask read taken while a poll is armed each check that the stored state was left alone. Idle and half-selected bus states catch a data bus that leaks values while it should float.

// File: rtl/pic_rd_pkg.sv
// Shared types and field positions for the status readback path.
// Assumes an 8-bit command word; the bit positions are fixed by the
// neighbouring command decoders and must not move.
package pic_rd_pkg;
    // Command word field positions
    localparam int FMT_HI_BIT = 4;  // 1 = initialisation word
    localparam int FMT_LO_BIT = 3;  // with FMT_HI = 0: 1 = status command
    localparam int POLL_BIT   = 2;
    localparam int RDREG_BIT  = 1;
    localparam int RSEL_BIT   = 0;

    typedef enum logic {
        SEL_REQ = 1'b0,
        SEL_SVC = 1'b1
    } rdsel_e;

    typedef struct packed {
        logic init_wr;   // initialisation word
        logic mask_wr;   // mask register load
        logic stat_wr;   // status command word
    } wr_kind_t;
endpackage

// File: rtl/pic_cmd_decode.sv
// Turns the asynchronous-looking bus strobes into single-cycle write
// pulses and a read-end pulse. Assumes the strobes are already
// synchronous to clk. A write acts on its first active cycle.
module pic_cmd_decode
    import pic_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       a0,
    input  logic [4:0] ctl,       // low command bits from the data bus
    output wr_kind_t   kind,
    output logic       poll_req,
    output logic       rdreg_req,
    output logic       rsel_req,
    output logic       rd_active,
    output logic       rd_end_lo  // an address-0 read has just ended
);
    logic wr_act, wr_q, wr_stb;
    logic rd_q, rd_a0_q;

    assign wr_act    = !cs_n && !wr_n;
    assign rd_active = !cs_n && !rd_n;
    assign wr_stb    = wr_act && !wr_q;

    // Track strobe history for edge detection and read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            rd_a0_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_active;
            if (rd_active) rd_a0_q <= a0;
        end
    end

    // Classify the write and break out the status command fields.
    always_comb begin
        kind.init_wr = wr_stb && !a0 &&  ctl[FMT_HI_BIT];
        kind.stat_wr = wr_stb && !a0 && !ctl[FMT_HI_BIT] && ctl[FMT_LO_BIT];
        kind.mask_wr = wr_stb &&  a0;
        poll_req     = ctl[POLL_BIT];
        rdreg_req    = ctl[RDREG_BIT];
        rsel_req     = ctl[RSEL_BIT];
    end

    assign rd_end_lo = rd_q && !rd_active && !rd_a0_q;
endmodule

// File: rtl/pic_sel_state.sv
// Holds the sticky register choice, the line mask and the armed-poll
// flag. Assumes at most one write pulse per cycle from the decoder.
module pic_sel_state
    import pic_rd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_kind_t      kind,
    input  logic          poll_req,
    input  logic          rdreg_req,
    input  logic          rsel_req,
    input  logic          rd_end_lo,
    input  logic [DW-1:0] din,
    output rdsel_e        sel,
    output logic [DW-1:0] mask,
    output logic          poll_q
);
    // Update choice, mask and poll flag from writes and read ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= SEL_REQ;
            mask   <= '0;
            poll_q <= 1'b0;
        end else if (kind.init_wr) begin
            sel    <= SEL_REQ;
            mask   <= '0;
            poll_q <= 1'b0;
        end else begin
            if (rd_end_lo && poll_q) begin
                poll_q <= 1'b0;
                sel    <= SEL_REQ;
            end
            if (kind.mask_wr) mask <= din;
            if (kind.stat_wr) begin
                if (poll_req)       poll_q <= 1'b1;
                else if (rdreg_req) sel    <= rsel_req ? SEL_SVC : SEL_REQ;
            end
        end
    end

    // R9
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind.init_wr |=> (sel == SEL_REQ) && (mask == '0) && !poll_q);
    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind.mask_wr && !kind.init_wr) |=> (mask == $past(din)));
    // R5
    nosel_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind.stat_wr && !kind.init_wr && !rdreg_req && !poll_req && !rd_end_lo)
        |=> (sel == $past(sel)));
    // R8
    poll_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end_lo && poll_q && !kind.init_wr && !kind.stat_wr)
        |=> (!poll_q && sel == SEL_REQ));
endmodule

// File: rtl/pic_read_mux.sv
// Builds the read data: mask, poll byte or the chosen status vector,
// and holds the bus at zero when not driving. Fixed priority: line 0
// is highest.
module pic_read_mux
    import pic_rd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oe,
    input  logic          a0,
    input  rdsel_e        sel,
    input  logic          poll_q,
    input  logic [DW-1:0] irr,
    input  logic [DW-1:0] isr,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] dout
);
    localparam int LVL_W = $clog2(DW);

    logic [DW-1:0]    pend;
    logic [LVL_W-1:0] lvl;
    logic [DW-1:0]    poll_byte;
    logic [DW-1:0]    below [DW];  // below[i]: pending lines under i

    assign pend = irr & ~mask;

    // Lower-line occupancy per position, one slice per line.
    for (genvar g = 0; g < DW; g++) begin : g_below
        if (g == 0) begin : g_first
            assign below[g] = '0;
        end else begin : g_rest
            assign below[g] = below[g-1] | (pend & (DW'(1) << (g - 1)));
        end
    end

    // Encode the lowest pending line.
    always_comb begin
        lvl = '0;
        for (int i = 0; i < DW; i++) begin
            if (pend[i] && (below[i] == '0)) lvl = LVL_W'(i);
        end
    end

    // Assemble poll byte.
    always_comb begin
        poll_byte            = '0;
        poll_byte[DW-1]      = |pend;
        poll_byte[LVL_W-1:0] = lvl;
    end

    // Select read data.
    always_comb begin
        if (!oe)                 dout = '0;
        else if (a0)             dout = mask;
        else if (poll_q)         dout = poll_byte;
        else if (sel == SEL_SVC) dout = isr;
        else                     dout = irr;
    end

    // R10
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (dout == '0));
    // R7
    poll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !a0 && poll_q) |-> (dout[DW-1] == (|(irr & ~mask))));
    // R7
    poll_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !a0 && poll_q && |(irr & ~mask)) |-> pend[dout[LVL_W-1:0]]);
endmodule

// File: rtl/pic_status_read.sv
// Top of the status readback path: strobe decode, sticky choice
// state and read data mux. Request and in-service vectors are live
// inputs owned by neighbouring logic.
module pic_status_read
    import pic_rd_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [NLINES-1:0] din,
    input  logic [NLINES-1:0] irr_i,
    input  logic [NLINES-1:0] isr_i,
    output logic [NLINES-1:0] dout,
    output logic              dout_oe
);
    localparam int DW = NLINES;

    wr_kind_t      kind;
    logic          poll_req, rdreg_req, rsel_req, rd_active, rd_end_lo;
    rdsel_e        sel;
    logic [DW-1:0] mask;
    logic          poll_q;

    pic_cmd_decode i_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .ctl(din[4:0]), .kind(kind), .poll_req(poll_req),
        .rdreg_req(rdreg_req), .rsel_req(rsel_req),
        .rd_active(rd_active), .rd_end_lo(rd_end_lo)
    );

    pic_sel_state #(.DW(DW)) i_state (
        .clk(clk), .rst_n(rst_n), .kind(kind), .poll_req(poll_req),
        .rdreg_req(rdreg_req), .rsel_req(rsel_req), .rd_end_lo(rd_end_lo),
        .din(din), .sel(sel), .mask(mask), .poll_q(poll_q)
    );

    pic_read_mux #(.DW(DW)) i_mux (
        .clk(clk), .rst_n(rst_n), .oe(rd_active), .a0(a0), .sel(sel),
        .poll_q(poll_q), .irr(irr_i), .isr(isr_i), .mask(mask), .dout(dout)
    );

    assign dout_oe = rd_active;
endmodule

// File: tb/test_pic_status_read.sv
module test_pic_status_read;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = '0, irr_i = '0, isr_i = '0;
    logic [7:0] dout;
    logic       dout_oe;
    int         n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pic_status_read i_pic_status_read (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .irr_i(irr_i), .isr_i(isr_i),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; din = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] q, output logic o);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = a;
        #(CLK_P/4);
        q = dout; o = dout_oe;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] poll_exp(input logic [7:0] r, input logic [7:0] m);
        logic [7:0] p = r & ~m;
        logic [7:0] res = 8'h00;
        for (int i = 7; i >= 0; i--) if (p[i]) res = 8'h80 | 8'(i);
        return res;
    endfunction

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] q;
        logic       o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 idle bus and half-selected states
        #(CLK_P/4);
        chk("R10 idle oe", {7'd0, dout_oe}, 8'h00);
        chk("R10 idle data", dout, 8'h00);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; irr_i = 8'hA5; #(CLK_P/4);
        chk("R10 cs high oe", {7'd0, dout_oe}, 8'h00);
        chk("R10 cs high data", dout, 8'h00);
        @(negedge clk); rd_n = 1'b1;
        // R1 reset state: request choice, mask zero, no poll
        irr_i = 8'h3C; isr_i = 8'hC3;
        rd(1'b0, q, o);
        chk("R1 reset choice", q, 8'h3C);
        chk("R10 read oe", {7'd0, o}, 8'h01);
        rd(1'b1, q, o);
        chk("R1 reset mask", q, 8'h00);
        // R3 in-service choice, R4 sticky across sweep
        wr(1'b0, 8'h0B);
        for (int v = 0; v < 256; v += 17) begin
            irr_i = 8'(v); isr_i = 8'((v * 37 + 11) & 255);
            rd(1'b0, q, o);
            chk("R3/R4 svc sticky", q, isr_i);
        end
        // R5 no-select command keeps in-service choice
        wr(1'b0, 8'h08);
        rd(1'b0, q, o);
        chk("R5 keep choice", q, isr_i);
        // R2 request choice, R4 sticky
        wr(1'b0, 8'h0A);
        for (int v = 0; v < 256; v += 15) begin
            irr_i = 8'(v); isr_i = ~8'(v);
            rd(1'b0, q, o);
            chk("R2/R4 req sticky", q, irr_i);
        end
        // R6 mask load and readback independent of choice
        wr(1'b0, 8'h0B);
        wr(1'b1, 8'h5A);
        rd(1'b1, q, o);
        chk("R6 mask read", q, 8'h5A);
        rd(1'b0, q, o);
        chk("R6 choice kept", q, isr_i);
        // R11 format-00 write leaves state alone
        wr(1'b0, 8'h20);
        rd(1'b0, q, o);
        chk("R11 choice kept", q, isr_i);
        rd(1'b1, q, o);
        chk("R11 mask kept", q, 8'h5A);
        // R7/R8 poll sweep over all request patterns and several masks
        for (int m = 0; m < 3; m++) begin
            logic [7:0] mk;
            mk = (m == 0) ? 8'h00 : (m == 1) ? 8'h0F : 8'hA0;
            wr(1'b1, mk);
            for (int v = 0; v < 256; v++) begin
                irr_i = 8'(v); isr_i = 8'((v * 5 + 3) & 255);
                wr(1'b0, 8'h0B);          // choose in-service
                wr(1'b0, 8'h0C);          // arm poll
                if (v == 77) begin
                    rd(1'b1, q, o);       // mask read leaves poll armed
                    chk("R8 addr1 keeps poll", q, mk);
                end
                rd(1'b0, q, o);
                chk("R7 poll byte", q, poll_exp(irr_i, mk));
                rd(1'b0, q, o);
                chk("R8 back to request", q, irr_i);
            end
        end
        // R9 initialisation word
        wr(1'b1, 8'hF0);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h0C);
        wr(1'b0, 8'h13);
        irr_i = 8'h81; isr_i = 8'h18;
        rd(1'b0, q, o);
        chk("R9 choice request no poll", q, 8'h81);
        rd(1'b1, q, o);
        chk("R9 mask cleared", q, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule